// File: doc/BRIEF.md
# Fan-Control Register Bank with Write Protection

This block holds the byte-wide configuration registers of a temperature-monitoring and fan-control device. A simple synchronous bus reaches it: an 8-bit address, a write strobe, a read strobe, write data and registered read data. On every access the block decides whether a write may change the addressed bits and what a read returns. The decision depends on a one-way lock bit, a start bit, a low-power shutdown state and each fan channel's manual or automatic mode.

Its registers are per-fan duty-cycle registers, per-fan mode registers, generic limit registers, a special-function register, a configuration register and event status registers. A status bit is set by an event pulse and is cleared by a read, but the read clears nothing while any monitored condition of that register is still active. Register contents drive the device's control outputs directly.

Top module: `fan_reg_guard`

## Requirements
- R1: After reset, the duty registers (0x30 to 0x32) read 0xFF, the limit registers (0x40 to 0x43) read 0x80, the fan mode registers (0x5C to 0x5E) read 0x62, and the special-function register (0x7C), the configuration register (0x7F) and the status registers (0x88, 0x89) all read 0x00.
- R2: A read of an address that holds no register returns 0x00. A write to such an address changes no register.
- R3: Configuration bit 1 is the lock. Once it is set, writes leave the limit registers, the fan mode registers, configuration bits 0, 1, 2 and 7:4, and special-function bits 1:0 and 7:3 unchanged. After that only reset clears the lock.
- R4: A fan's duty register accepts a write only while that fan's mode field (bits 7:5 of its mode register) equals 3'b111 (manual) and the lock is clear. The start bit (configuration bit 0) has no effect on this.
- R5: Configuration bit 3 (override) takes every write to 0x7F, whatever the lock and start bits hold.
- R6: Special-function bit 2 (interrupt enable) takes every write to 0x7C, whatever the lock and start bits hold.
- R7: A status bit is set by a one-cycle pulse on its event input. A read of its register clears the register only if none of that register's active inputs is high in the read cycle. A pulse in the same cycle as a clearing read leaves its bit set.
- R8: Shutdown is configuration bit 2 = 1 with bit 0 = 0. In shutdown every register other than 0x7F reads 0x00 and ignores writes, except that bits 2:0 of 0x7C stay readable and writable. Status reads in shutdown clear nothing.
- R9: rdata_o updates on the clock edge that samples rd_i. It shows the register contents from before that edge and holds while rd_i is low.
- R10: Reserved bits (configuration bits 7:4, special-function bits 1:0) store and return the written value while the lock is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| evt_i | input | NUM_STAT*8 | Event pulses, byte j sets status register j |
| evt_act_i | input | NUM_STAT*8 | Active event levels, byte j blocks clearing of status register j |
| start_o | output | 1 | Start bit |
| lock_o | output | 1 | Lock bit |
| ovrid_o | output | 1 | Override bit |
| int_en_o | output | 1 | Interrupt enable |
| fan_manual_o | output | NUM_FAN | Per-fan manual mode flag |
| duty_o | output | NUM_FAN*8 | Per-fan duty-cycle values |

## Verification
Most faulty internal states appear on the next read of the affected register. A read returns its value one cycle after the read strobe. A lock that falls back to zero or fails to protect a register appears as a changed read value right after the rejected write. A wrong shutdown qualification appears on a read taken during shutdown, or on a read taken after shutdown ends, which shows whether a blocked write or clear got through. Status clearing faults appear on the second of two back-to-back reads, and the direct control outputs show lock, start and mode faults on the cycle after the write.

// File: rtl/fan_reg_guard_pkg.sv
package fan_reg_guard_pkg;
  localparam int unsigned DW = 8;

  localparam logic [7:0] A_DUTY0 = 8'h30;
  localparam logic [7:0] A_LIM0  = 8'h40;
  localparam logic [7:0] A_MODE0 = 8'h5C;
  localparam logic [7:0] A_SFR   = 8'h7C;
  localparam logic [7:0] A_CFG   = 8'h7F;
  localparam logic [7:0] A_STAT0 = 8'h88;

  localparam logic [7:0] DEF_DUTY = 8'hFF;
  localparam logic [7:0] DEF_LIM  = 8'h80;
  localparam logic [7:0] DEF_MODE = 8'h62;
  localparam logic [7:0] DEF_SFR  = 8'h00;

  localparam int unsigned SFR_INT_EN   = 2;
  localparam logic [7:0]  SFR_OPEN_MSK = 8'h07;
  localparam logic [2:0]  MODE_MANUAL  = 3'b111;

  typedef struct packed {
    logic [3:0] rsv;
    logic       ovrid;
    logic       low_pwr;
    logic       lock;
    logic       start;
  } cfg_t;

  function automatic logic in_win(logic [7:0] a, logic [7:0] base, int unsigned n);
    return (a >= base) && ({1'b0, a} < ({1'b0, base} + 9'(n)));
  endfunction
endpackage

// File: rtl/fan_reg_guard_ctl.sv
module fan_reg_guard_ctl
  import fan_reg_guard_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        cfg_sel_i,
  input  logic        sfr_sel_i,
  input  logic [7:0]  wdata_i,
  output cfg_t        cfg_o,
  output logic [7:0]  sfr_o,
  output logic        shdn_o
);
  cfg_t       cfg_q;
  logic [7:0] sfr_q;
  logic [7:0] sfr_msk;

  assign shdn_o = cfg_q.low_pwr & ~cfg_q.start;

  always_comb begin
    sfr_msk = cfg_q.lock ? (8'h01 << SFR_INT_EN) : 8'hFF;
    if (shdn_o) sfr_msk = sfr_msk & SFR_OPEN_MSK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      sfr_q <= DEF_SFR;
    end else if (wr_i) begin
      if (cfg_sel_i) begin
        if (cfg_q.lock) cfg_q.ovrid <= wdata_i[3];
        else            cfg_q       <= cfg_t'(wdata_i);
      end
      if (sfr_sel_i) sfr_q <= (sfr_q & ~sfr_msk) | (wdata_i & sfr_msk);
    end
  end

  assign cfg_o = cfg_q;
  assign sfr_o = sfr_q;

  p_lock_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.lock |=> cfg_q.lock);
  p_ovrid_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && cfg_sel_i) |=> cfg_q.ovrid == $past(wdata_i[3]));
  p_int_en_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sfr_sel_i) |=> sfr_q[SFR_INT_EN] == $past(wdata_i[SFR_INT_EN]));
endmodule

// File: rtl/fan_reg_guard_fan.sv
module fan_reg_guard_fan
  import fan_reg_guard_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       mode_sel_i,
  input  logic       duty_sel_i,
  input  logic [7:0] wdata_i,
  input  logic       lock_i,
  input  logic       shdn_i,
  output logic [7:0] mode_o,
  output logic [7:0] duty_o,
  output logic       manual_o
);
  logic [7:0] mode_q, duty_q;
  logic       open_w;

  assign open_w   = wr_i & ~lock_i & ~shdn_i;
  assign manual_o = (mode_q[7:5] == MODE_MANUAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= DEF_MODE;
      duty_q <= DEF_DUTY;
    end else begin
      if (open_w && mode_sel_i)             mode_q <= wdata_i;
      if (open_w && duty_sel_i && manual_o) duty_q <= wdata_i;
    end
  end

  assign mode_o = mode_q;
  assign duty_o = duty_q;

  p_duty_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(duty_q));
  p_duty_auto_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !manual_o |=> $stable(duty_q));
  p_mode_lock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(mode_q));
endmodule

// File: rtl/fan_reg_guard_stat.sv
module fan_reg_guard_stat (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] evt_i,
  input  logic [7:0] act_i,
  input  logic       rd_clr_i,
  output logic [7:0] stat_o
);
  logic [7:0] stat_q;
  logic       clr_w;

  assign clr_w = rd_clr_i & ~(|act_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stat_q <= '0;
    else if (clr_w) stat_q <= evt_i;
    else            stat_q <= stat_q | evt_i;
  end

  assign stat_o = stat_q;

  p_stat_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));
  p_stat_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|act_i) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  p_stat_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !(|act_i) && !(|evt_i)) |=> (stat_q == 8'h00));
endmodule

// File: rtl/fan_reg_guard.sv
module fan_reg_guard
  import fan_reg_guard_pkg::*;
#(
  parameter int unsigned NUM_FAN  = 3,
  parameter int unsigned NUM_LIM  = 4,
  parameter int unsigned NUM_STAT = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [7:0]            addr_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [7:0]            wdata_i,
  output logic [7:0]            rdata_o,
  input  logic [NUM_STAT*8-1:0] evt_i,
  input  logic [NUM_STAT*8-1:0] evt_act_i,
  output logic                  start_o,
  output logic                  lock_o,
  output logic                  ovrid_o,
  output logic                  int_en_o,
  output logic [NUM_FAN-1:0]    fan_manual_o,
  output logic [NUM_FAN*8-1:0]  duty_o
);
  localparam int unsigned SW = NUM_STAT * 8;

  cfg_t       cfg_w;
  logic [7:0] sfr_w;
  logic       shdn_w;
  logic       cfg_sel, sfr_sel, hit_any;
  logic [7:0] rd_val;
  logic [7:0] rdata_q;

  logic [7:0] mode_w [NUM_FAN];
  logic [7:0] duty_w [NUM_FAN];
  logic [7:0] lim_q  [NUM_LIM];
  logic [7:0] stat_w [NUM_STAT];

  assign cfg_sel = (addr_i == A_CFG);
  assign sfr_sel = (addr_i == A_SFR);
  assign hit_any = cfg_sel | sfr_sel
                 | in_win(addr_i, A_DUTY0, NUM_FAN)
                 | in_win(addr_i, A_MODE0, NUM_FAN)
                 | in_win(addr_i, A_LIM0,  NUM_LIM)
                 | in_win(addr_i, A_STAT0, NUM_STAT);

  fan_reg_guard_ctl u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .cfg_sel_i (cfg_sel),
    .sfr_sel_i (sfr_sel),
    .wdata_i   (wdata_i),
    .cfg_o     (cfg_w),
    .sfr_o     (sfr_w),
    .shdn_o    (shdn_w)
  );

  for (genvar f = 0; f < NUM_FAN; f++) begin : g_fan
    fan_reg_guard_fan u_fan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_i),
      .mode_sel_i (addr_i == 8'(A_MODE0 + f)),
      .duty_sel_i (addr_i == 8'(A_DUTY0 + f)),
      .wdata_i    (wdata_i),
      .lock_i     (cfg_w.lock),
      .shdn_i     (shdn_w),
      .mode_o     (mode_w[f]),
      .duty_o     (duty_w[f]),
      .manual_o   (fan_manual_o[f])
    );
    assign duty_o[f*8 +: 8] = duty_w[f];
  end

  for (genvar l = 0; l < NUM_LIM; l++) begin : g_lim
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lim_q[l] <= DEF_LIM;
      else if (wr_i && addr_i == 8'(A_LIM0 + l) && !cfg_w.lock && !shdn_w)
        lim_q[l] <= wdata_i;
    end
  end

  for (genvar s = 0; s < NUM_STAT; s++) begin : g_stat
    fan_reg_guard_stat u_stat (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_i[s*8 +: 8]),
      .act_i    (evt_act_i[s*8 +: 8]),
      .rd_clr_i (rd_i && !shdn_w && addr_i == 8'(A_STAT0 + s)),
      .stat_o   (stat_w[s])
    );
  end

  always_comb begin
    rd_val = 8'h00;
    if (cfg_sel) rd_val = cfg_w;
    else if (sfr_sel) rd_val = shdn_w ? (sfr_w & SFR_OPEN_MSK) : sfr_w;
    else if (!shdn_w) begin
      for (int i = 0; i < NUM_FAN; i++) begin
        if (addr_i == 8'(A_DUTY0 + i)) rd_val = duty_w[i];
        if (addr_i == 8'(A_MODE0 + i)) rd_val = mode_w[i];
      end
      for (int i = 0; i < NUM_LIM; i++)
        if (addr_i == 8'(A_LIM0 + i)) rd_val = lim_q[i];
      for (int i = 0; i < NUM_STAT; i++)
        if (addr_i == 8'(A_STAT0 + i)) rd_val = stat_w[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= 8'h00;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o  = rdata_q;
  assign start_o  = cfg_w.start;
  assign lock_o   = cfg_w.lock;
  assign ovrid_o  = cfg_w.ovrid;
  assign int_en_o = sfr_w[SFR_INT_EN];

  logic unused_sw;
  assign unused_sw = (SW == 0);

  p_undef_rd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !hit_any) |=> (rdata_o == 8'h00));
  p_shdn_rd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && shdn_w && !cfg_sel && !sfr_sel) |=> (rdata_o == 8'h00));
  p_rd_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  p_lim_lock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_w.lock |=> $stable(lim_q[0]));
endmodule

// File: tb/fan_reg_guard_bench.sv
`timescale 1ns/1ps
module fan_reg_guard_bench;
  localparam int NF = 3, NL = 4, NS = 2;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [7:0]    addr = '0, wdata = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [7:0]    rdata;
  logic [NS*8-1:0] evt = '0, act = '0;
  logic          start, lock, ovrid, int_en;
  logic [NF-1:0] manual;
  logic [NF*8-1:0] duty;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  fan_reg_guard #(.NUM_FAN(NF), .NUM_LIM(NL), .NUM_STAT(NS)) u_fan_reg_guard (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .evt_act_i(act),
    .start_o(start), .lock_o(lock), .ovrid_o(ovrid), .int_en_o(int_en),
    .fan_manual_o(manual), .duty_o(duty)
  );

  // monitor: pops one expected item per completed read
  always @(posedge clk) pend <= rd;
  always @(negedge clk) begin
    if (pend) begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      n_chk++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s: rdata actual %02h expected %02h", t, rdata, e);
      end
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk); exp_q.push_back(e); tag_q.push_back(t); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic pulse(input int k);
    @(negedge clk); evt[k] = 1'b1;
    @(negedge clk); evt = '0;
  endtask

  task automatic chk(input logic [31:0] act_v, input logic [31:0] exp_v, input string t);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", t, act_v, exp_v);
    end
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset defaults
    for (int i = 0; i < NF; i++) rd_reg(8'(8'h30 + i), 8'hFF, "R1 duty");
    for (int i = 0; i < NL; i++) rd_reg(8'(8'h40 + i), 8'h80, "R1 limit");
    for (int i = 0; i < NF; i++) rd_reg(8'(8'h5C + i), 8'h62, "R1 mode");
    rd_reg(8'h7C, 8'h00, "R1 sfr");
    rd_reg(8'h7F, 8'h00, "R1 cfg");
    rd_reg(8'h88, 8'h00, "R1 stat0");
    rd_reg(8'h89, 8'h00, "R1 stat1");
    chk(32'(lock), 0, "R1 lock_o");
    chk(32'(duty), 32'hFFFFFF, "R1 duty_o");
    // R2 undefined addresses
    wr_reg(8'h10, 8'h55);
    rd_reg(8'h10, 8'h00, "R2 undef 10");
    rd_reg(8'hFF, 8'h00, "R2 undef FF");
    rd_reg(8'h44, 8'h00, "R2 undef 44");
    // R4 duty needs manual mode
    wr_reg(8'h30, 8'h40);
    rd_reg(8'h30, 8'hFF, "R4 duty auto ignored");
    wr_reg(8'h5C, 8'hE0);
    chk(32'(manual), 32'h1, "R4 manual flag");
    wr_reg(8'h30, 8'h40);
    rd_reg(8'h30, 8'h40, "R4 duty manual");
    wr_reg(8'h7F, 8'h01);
    wr_reg(8'h30, 8'h55);
    rd_reg(8'h30, 8'h55, "R4 duty with start");
    // R10 reserved bits
    wr_reg(8'h7F, 8'hA1);
    rd_reg(8'h7F, 8'hA1, "R10 cfg reserved");
    chk(32'(start), 1, "R10 start_o");
    wr_reg(8'h41, 8'h33);
    rd_reg(8'h41, 8'h33, "R1 limit write");
    // R7 status
    pulse(0);
    rd_reg(8'h88, 8'h01, "R7 set");
    rd_reg(8'h88, 8'h00, "R7 cleared");
    pulse(1);
    @(negedge clk); act[1] = 1'b1;
    rd_reg(8'h88, 8'h02, "R7 active read");
    rd_reg(8'h88, 8'h02, "R7 held while active");
    @(negedge clk); act = '0;
    rd_reg(8'h88, 8'h02, "R7 read after inactive");
    rd_reg(8'h88, 8'h00, "R7 cleared after inactive");
    pulse(2);
    @(negedge clk); exp_q.push_back(8'h04); tag_q.push_back("R7 read with pulse");
    addr = 8'h88; rd = 1'b1; evt[3] = 1'b1;
    @(negedge clk); rd = 1'b0; evt = '0;
    rd_reg(8'h88, 8'h08, "R7 set wins");
    rd_reg(8'h88, 8'h00, "R7 final clear");
    // R9 read data holds
    @(negedge clk); chk(32'(rdata), 0, "R9 hold");
    // R8 shutdown
    wr_reg(8'h7F, 8'h04);
    rd_reg(8'h7F, 8'h04, "R8 cfg visible");
    rd_reg(8'h41, 8'h00, "R8 limit hidden");
    wr_reg(8'h41, 8'h77);
    wr_reg(8'h7C, 8'hFF);
    rd_reg(8'h7C, 8'h07, "R8 sfr low bits");
    chk(32'(int_en), 1, "R6 int_en_o");
    pulse(8);
    rd_reg(8'h89, 8'h00, "R8 stat hidden");
    wr_reg(8'h7F, 8'h00);
    rd_reg(8'h41, 8'h33, "R8 limit write ignored");
    rd_reg(8'h89, 8'h01, "R8 stat not cleared");
    rd_reg(8'h7C, 8'h07, "R8 sfr high bits unchanged");
    // R3 lock
    wr_reg(8'h7F, 8'h03);
    chk(32'(lock), 1, "R3 lock_o set");
    wr_reg(8'h41, 8'h99);
    rd_reg(8'h41, 8'h33, "R3 limit locked");
    wr_reg(8'h5C, 8'h00);
    rd_reg(8'h5C, 8'hE0, "R3 mode locked");
    wr_reg(8'h30, 8'h11);
    rd_reg(8'h30, 8'h55, "R4 duty locked");
    // R5 override always writable
    wr_reg(8'h7F, 8'h08);
    rd_reg(8'h7F, 8'h0B, "R5 ovrid under lock");
    chk(32'(lock), 1, "R3 lock not cleared");
    chk(32'(ovrid), 1, "R5 ovrid_o");
    // R6 int enable always writable
    wr_reg(8'h7C, 8'h00);
    rd_reg(8'h7C, 8'h03, "R6 int_en cleared under lock");
    wr_reg(8'h7C, 8'hFF);
    rd_reg(8'h7C, 8'h07, "R6 int_en set under lock");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule